// File: doc/BRIEF.md
# Bus Idle-Gap Detector and Slave Break Generator

This block sits beside the byte receiver of a two-wire synchronous bus made of a clock line and an open-drain data line. It runs from a periodic enable tick of nominally 500 us. It has two jobs, and one shared tick counter serves both.

The first job is to watch the bus clock for silence. When no clock edge has been seen for a set number of ticks, the block pulses `gap_found`. That pulse re-arms the byte receiver and clears the receiver's packet state.

The second job starts on request. The block then generates a slave break that tells the bus master this device needs attention. It first waits until the data line has stayed low for a set number of ticks. It then waits a further set number of ticks. Last, it pulls data low for a set number of ticks and releases it. The line is touched only through `drive_low`, which acts as an open-drain pull-down. Gap detection is suspended while the break runs, and the edge history is discarded when the break ends.

Top module: `bus_gap_break`

## Requirements
- R1: During and directly after a synchronous active-low reset, `gap_found`, `drive_low` and `brk_busy` are all 0.
- R2: While no break runs, `gap_found` is a one-cycle pulse. It appears in the cycle after the tick that completes GAP_TICKS (8) consecutive ticks with no bus clock edge since the previous tick.
- R3: Both a rising and a falling edge of the synchronized bus clock restart the quiet-tick count.
- R4: A gap is reported once. A new pulse needs at least one clock edge followed by another full run of GAP_TICKS quiet ticks.
- R5: A `brk_req` sampled high while no break runs starts a break. `brk_busy` is 1 from the next cycle until the break ends.
- R6: In the first break phase, each tick with bus data high (1) clears the count. The phase ends on the LOW_TICKS-th (12) consecutive tick with data low (0).
- R7: The second phase lasts WAIT_TICKS (8) ticks. `drive_low` rises in the cycle after its last tick.
- R8: `drive_low` stays 1 for HOLD_TICKS (8) ticks. In the cycle after the last of them, `drive_low` and `brk_busy` both return to 0 together.
- R9: No `gap_found` pulse occurs during a break. Clock edges seen during a break are forgotten, and the quiet count starts from zero when the break ends.
- R10: A `brk_req` that arrives while a break is running has no effect on the break's timing.
- R11: If the tick that completes a gap coincides with a `brk_req`, both take effect: `gap_found` pulses and `brk_busy` rises in the same cycle.
- R12: `drive_low` is never 1 unless `brk_busy` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle enable pulse, one per 500 us period |
| bus_clk | input | 1 | Bus clock line, asynchronous, idle high |
| bus_dat | input | 1 | Bus data line as seen on the wire, asynchronous |
| brk_req | input | 1 | Request to generate a slave break |
| gap_found | output | 1 | One-cycle pulse when a clock-idle gap is detected |
| drive_low | output | 1 | Open-drain pull-down enable for the data line |
| brk_busy | output | 1 | High while a break sequence runs |

## Verification
The two functions that can land on the same cycle are gap completion and break start. The bench provokes this by holding the bus clock quiet for seven ticks and then raising `brk_req` together with the eighth tick. It then expects to see `gap_found` and `brk_busy` both high in the following cycle. After that it runs the break to its end, to show that the gap bookkeeping left by that cycle does not disturb the break's phase timing. A second overlap is also tested: a clock edge that arrives during a break must not count afterwards. This is judged by requiring exactly GAP_TICKS quiet ticks after release before the next pulse.

// File: rtl/bus_gap_break_pkg.sv
// Shared types and helpers for the bus gap detector / break generator.
package bus_gap_break_pkg;

    // Sequencer phase: watching for a gap, or one of three break phases.
    typedef enum logic [1:0] {
        PH_WATCH = 2'd0,
        PH_LOW   = 2'd1,
        PH_WAIT  = 2'd2,
        PH_HOLD  = 2'd3
    } gb_phase_e;

    // Larger of two integers, used to size the shared counter.
    function automatic int gb_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/bus_gap_sync.sv
// Multi-stage synchronizer for a vector of asynchronous inputs.
// Assumes each bit is independent (no bus coherency needed) and that the
// reset value matches the idle level of the lines.
module bus_gap_sync #(
    parameter int              WIDTH     = 2,
    parameter int              STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage samples the raw asynchronous input.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= RESET_VAL;
                else        stg[g] <= din;
            end
        end else begin : g_next
            // Later stages resolve metastability.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= RESET_VAL;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/bus_gap_edge.sv
// Edge detector for the synchronized bus clock: flags any change, rising
// or falling. Assumes the input is already synchronous to clk.
module bus_gap_edge #(
    parameter logic IDLE_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic edge_seen
);
    logic sig_q;

    // Remember the previous synchronized level.
    always_ff @(posedge clk) begin
        if (!rst_n) sig_q <= IDLE_LEVEL;
        else        sig_q <= sig;
    end

    assign edge_seen = sig ^ sig_q;
endmodule

// File: rtl/bus_gap_seq.sv
// Tick-driven sequencer: gap detection and three-phase slave break, sharing
// one counter. Assumes tick is a single-cycle pulse and that clk_edge and
// dat_s are synchronous to clk.
module bus_gap_seq
    import bus_gap_break_pkg::*;
#(
    parameter int GAP_TICKS  = 8,
    parameter int LOW_TICKS  = 12,
    parameter int WAIT_TICKS = 8,
    parameter int HOLD_TICKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic clk_edge,
    input  logic dat_s,
    input  logic brk_req,
    output logic gap_found,
    output logic drive_low,
    output logic brk_busy
);
    localparam int CNT_MAX = gb_max(gb_max(GAP_TICKS, LOW_TICKS),
                                    gb_max(WAIT_TICKS, HOLD_TICKS));
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] GAP_LAST  = CNT_W'(GAP_TICKS - 1);
    localparam logic [CNT_W-1:0] LOW_LAST  = CNT_W'(LOW_TICKS - 1);
    localparam logic [CNT_W-1:0] WAIT_LAST = CNT_W'(WAIT_TICKS - 1);
    localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_TICKS - 1);

    gb_phase_e        phase;
    logic [CNT_W-1:0] cnt;
    logic             edge_pend;   // an edge arrived since the last tick
    logic             reported;    // current gap already announced
    logic             gap_q;
    logic             drive_q;
    logic             edge_any;

    // Edge seen either earlier in this tick period or in this very cycle.
    assign edge_any = edge_pend | clk_edge;

    // Phase, shared counter, and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_WATCH;
            cnt       <= '0;
            edge_pend <= 1'b0;
            reported  <= 1'b0;
            gap_q     <= 1'b0;
            drive_q   <= 1'b0;
        end else begin
            gap_q <= 1'b0;
            case (phase)
                PH_WATCH: begin
                    if (tick) begin
                        edge_pend <= 1'b0;
                        if (edge_any) begin
                            cnt      <= '0;
                            reported <= 1'b0;
                        end else if (!reported) begin
                            if (cnt == GAP_LAST) begin
                                gap_q    <= 1'b1;
                                cnt      <= '0;
                                reported <= 1'b1;
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                    end else if (clk_edge) begin
                        edge_pend <= 1'b1;
                    end
                    if (brk_req) begin
                        phase <= PH_LOW;
                        cnt   <= '0;
                    end
                end
                PH_LOW: begin
                    edge_pend <= 1'b0;
                    if (tick) begin
                        if (dat_s) begin
                            cnt <= '0;
                        end else if (cnt == LOW_LAST) begin
                            phase <= PH_WAIT;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                PH_WAIT: begin
                    edge_pend <= 1'b0;
                    if (tick) begin
                        if (cnt == WAIT_LAST) begin
                            phase   <= PH_HOLD;
                            cnt     <= '0;
                            drive_q <= 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                PH_HOLD: begin
                    edge_pend <= 1'b0;
                    if (tick) begin
                        if (cnt == HOLD_LAST) begin
                            phase    <= PH_WATCH;
                            cnt      <= '0;
                            drive_q  <= 1'b0;
                            reported <= 1'b0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: begin
                    phase   <= PH_WATCH;
                    cnt     <= '0;
                    drive_q <= 1'b0;
                end
            endcase
        end
    end

    assign gap_found = gap_q;
    assign drive_low = drive_q;
    assign brk_busy  = (phase != PH_WATCH);
endmodule

// File: rtl/bus_gap_break.sv
// Top level: synchronizes the bus lines, detects clock edges, and runs the
// gap/break sequencer. Assumes both bus lines idle high and that drive_low
// feeds an open-drain pull-down on the data line.
module bus_gap_break #(
    parameter int GAP_TICKS   = 8,
    parameter int LOW_TICKS   = 12,
    parameter int WAIT_TICKS  = 8,
    parameter int HOLD_TICKS  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic bus_clk,
    input  logic bus_dat,
    input  logic brk_req,
    output logic gap_found,
    output logic drive_low,
    output logic brk_busy
);
    logic [1:0] lines_s;
    logic       clk_edge;

    bus_gap_sync #(
        .WIDTH    (2),
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(2'b11)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({bus_dat, bus_clk}),
        .dout (lines_s)
    );

    bus_gap_edge #(
        .IDLE_LEVEL(1'b1)
    ) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .sig      (lines_s[0]),
        .edge_seen(clk_edge)
    );

    bus_gap_seq #(
        .GAP_TICKS (GAP_TICKS),
        .LOW_TICKS (LOW_TICKS),
        .WAIT_TICKS(WAIT_TICKS),
        .HOLD_TICKS(HOLD_TICKS)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .clk_edge (clk_edge),
        .dat_s    (lines_s[1]),
        .brk_req  (brk_req),
        .gap_found(gap_found),
        .drive_low(drive_low),
        .brk_busy (brk_busy)
    );
endmodule

// File: rtl/bus_gap_break_chk.sv
// Port-level property checker for bus_gap_break, attached by bind.
module bus_gap_break_chk (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic brk_req,
    input logic gap_found,
    input logic drive_low,
    input logic brk_busy
);
    // R2: the gap indication lasts a single cycle.
    a_r2_gap_single: assert property (@(posedge clk) disable iff (!rst_n)
        gap_found |=> !gap_found);

    // R2: a gap is only ever announced right after a tick.
    a_r2_gap_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gap_found) |-> $past(tick));

    // R5: an idle request starts the break on the next cycle.
    a_r5_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!brk_busy && brk_req) |=> brk_busy);

    // R7: the pull-down engages only in the cycle after a tick.
    a_r7_drive_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_low) |-> $past(tick));

    // R8: release of the line and end of the break coincide.
    a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drive_low) |-> !brk_busy);

    // R9: no gap pulse once a break has been running for a cycle.
    a_r9_no_gap_in_break: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_busy && $past(brk_busy)) |-> !gap_found);

    // R12: the line is driven only during a break.
    a_r12_drive_in_break: assert property (@(posedge clk) disable iff (!rst_n)
        drive_low |-> brk_busy);
endmodule

bind bus_gap_break bus_gap_break_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .brk_req  (brk_req),
    .gap_found(gap_found),
    .drive_low(drive_low),
    .brk_busy (brk_busy)
);

// File: tb/bus_gap_break_tb.sv
module bus_gap_break_tb;
    localparam int CLK_PERIOD = 10;
    localparam int GAP  = 8;
    localparam int LOW  = 12;
    localparam int WAIT = 8;
    localparam int HOLD = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic bus_clk = 1'b1;
    logic ext_low = 1'b0;
    logic brk_req = 1'b0;
    logic gap_found, drive_low, brk_busy;
    logic line_dat;

    int n_chk = 0;
    int n_fail = 0;

    // Open-drain data wire: low if anyone pulls it.
    assign line_dat = ~(ext_low | drive_low);

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_gap_break u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .bus_clk  (bus_clk),
        .bus_dat  (line_dat),
        .brk_req  (brk_req),
        .gap_found(gap_found),
        .drive_low(drive_low),
        .brk_busy (brk_busy)
    );

    task automatic chk(input logic act, input logic exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b at %0t", what, act, exp, $time);
        end
    endtask

    // One tick period of 10 cycles. Bus clock toggle early, tick at cycle 5.
    // g1 = gap_found right after the tick, g2 = one cycle later.
    task automatic step(input bit tog, input bit req, output logic g1, output logic g2);
        @(negedge clk);
        if (tog) bus_clk = ~bus_clk;
        repeat (5) @(negedge clk);
        tick = 1'b1;
        brk_req = req;
        @(negedge clk);
        tick = 1'b0;
        brk_req = 1'b0;
        g1 = gap_found;
        @(negedge clk);
        g2 = gap_found;
        repeat (2) @(negedge clk);
    endtask

    // Quiet ticks expecting no gap pulse.
    task automatic quiet(input int n, input string what);
        logic a, b;
        for (int i = 0; i < n; i++) begin
            step(1'b0, 1'b0, a, b);
            chk(a, 1'b0, what);
        end
    endtask

    // Tick-level reference of R2/R3/R4.
    int  m_cnt = 0;
    bit  m_rep = 0;
    function automatic logic model_step(input bit edge_in);
        logic e = 1'b0;
        if (edge_in) begin
            m_cnt = 0; m_rep = 0;
        end else if (!m_rep) begin
            if (m_cnt == GAP - 1) begin
                e = 1'b1; m_cnt = 0; m_rep = 1;
            end else m_cnt++;
        end
        return e;
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic g1, g2;
        void'($urandom(32'd20250));
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(gap_found, 1'b0, "R1 gap_found in reset");
        chk(drive_low, 1'b0, "R1 drive_low in reset");
        chk(brk_busy,  1'b0, "R1 brk_busy in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(gap_found | drive_low | brk_busy, 1'b0, "R1 outputs after reset");

        // R2: 7 quiet ticks silent, 8th pulses for one cycle
        quiet(GAP - 1, "R2 early gap");
        step(1'b0, 1'b0, g1, g2);
        chk(g1, 1'b1, "R2 gap on 8th quiet tick");
        chk(g2, 1'b0, "R2 gap pulse one cycle");

        // R4: no repeat while the line stays quiet
        quiet(10, "R4 repeated gap");

        // R3: falling edge restarts, then rising edge restarts mid-count
        step(1'b1, 1'b0, g1, g2);
        chk(g1, 1'b0, "R3 falling edge tick");
        quiet(5, "R3 partial count");
        step(1'b1, 1'b0, g1, g2);
        chk(g1, 1'b0, "R3 rising edge tick");
        quiet(GAP - 1, "R3 restarted count");
        step(1'b0, 1'b0, g1, g2);
        chk(g1, 1'b1, "R3 gap after rising edge restart");

        // R5: request starts the break
        @(negedge clk);
        brk_req = 1'b1;
        @(negedge clk);
        brk_req = 1'b0;
        chk(brk_busy, 1'b1, "R5 busy after request");
        // R6 + R9: data high holds phase 1, clock toggles must not raise gap
        for (int i = 0; i < 3; i++) begin
            step(1'b1, 1'b0, g1, g2);
            chk(g1, 1'b0, "R9 gap during break");
        end
        ext_low = 1'b1;
        for (int i = 0; i < LOW - 1; i++) begin
            step(1'b0, 1'b0, g1, g2);
            chk(g1, 1'b0, "R9 gap during break");
        end
        ext_low = 1'b0;  // data high resets phase-1 count (R6)
        step(1'b0, 1'b0, g1, g2);
        ext_low = 1'b1;
        for (int i = 0; i < LOW + WAIT - 1; i++) begin
            // R10: a request in the middle must not restart anything
            step(1'b0, (i == LOW + 2), g1, g2);
            chk(drive_low, 1'b0, "R6/R7 drive_low too early");
            chk(brk_busy, 1'b1, "R6 busy during low wait");
        end
        step(1'b0, 1'b0, g1, g2);
        chk(drive_low, 1'b1, "R7 drive_low after phase 2");
        ext_low = 1'b0;
        for (int i = 0; i < HOLD - 1; i++) begin
            step(1'b0, 1'b0, g1, g2);
            chk(drive_low, 1'b1, "R8 drive_low held");
            chk(brk_busy, 1'b1, "R8 busy during hold");
        end
        step(1'b0, 1'b0, g1, g2);
        chk(drive_low, 1'b0, "R8 drive_low released");
        chk(brk_busy, 1'b0, "R8 busy cleared with release");

        // R9: edges during break forgotten, count restarts from zero
        quiet(GAP - 1, "R9 early gap after break");
        step(1'b0, 1'b0, g1, g2);
        chk(g1, 1'b1, "R9 gap after 8 quiet ticks post-break");

        // R11: gap completion and request in one cycle
        step(1'b1, 1'b0, g1, g2);
        quiet(GAP - 1, "R11 early gap");
        step(1'b0, 1'b1, g1, g2);
        chk(g1, 1'b1, "R11 gap with request");
        chk(brk_busy, 1'b1, "R11 busy with gap");
        ext_low = 1'b1;
        for (int i = 0; i < LOW + WAIT - 1; i++) step(1'b0, 1'b0, g1, g2);
        chk(drive_low, 1'b0, "R11 drive_low timing before");
        step(1'b0, 1'b0, g1, g2);
        chk(drive_low, 1'b1, "R11 drive_low timing after");
        ext_low = 1'b0;
        for (int i = 0; i < HOLD; i++) step(1'b0, 1'b0, g1, g2);
        chk(brk_busy, 1'b0, "R11 break ends");

        // Random clock activity against the tick-level reference (R2-R4)
        m_cnt = 0; m_rep = 0;
        for (int i = 0; i < 300; i++) begin
            bit tg;
            logic exp;
            tg = ($urandom % 4) == 0;
            exp = model_step(tg);
            step(tg, 1'b0, g1, g2);
            chk(g1, exp, "R2/R3/R4 random gap");
            chk(g2, 1'b0, "R2 random pulse width");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule